// File: doc/BRIEF.md
# Converter Soft-Start Sequencer

This block brings a resonant half-bridge converter up from rest in two stages. It first runs open-loop at the highest allowed switching frequency and lengthens the primary on-time by a fixed amount on each slow tick. This limits inrush current while the output capacitor charges. When the on-time reaches 45 % of the fixed period, the block hands frequency control to an external compensator. It then holds the duty just under half of whatever period the compensator asks for, and ramps the voltage reference. The ramp starts from the measured pre-bias output voltage, not from zero, and ends at the target set-point.

All time quantities are counts of 250 ps. With the default parameters the fixed open-loop period is 4000 counts (1 MHz). The starting on-time is 200 counts (50 ns), each open-loop step is 10 counts (2.5 ns), and the dead time is 200 counts. The open-loop ramp therefore ends at an on-time of 1800 counts. A single abort input returns everything to idle at the next clock edge.

Top module: `softstart_seq`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows: `pwm_period` = 4000, `on_time` = 0, `vref` = 0, and `sr_en`, `loop_closed` and `done` all 0.
- R2: While idle, a `start_req` sampled high makes `on_time` 200 on the following cycle, with `pwm_period` held at 4000.
- R3: During the open-loop stage, each cycle with `tick` high adds 10 to `on_time` on the next cycle. Cycles without `tick` leave it unchanged.
- R4: The open-loop `on_time` never exceeds 1800. Once it reaches 1800, `loop_closed` rises on the next cycle. On the cycle after that, `vref` equals the smaller of `vout_meas` and `vref_target`, as sampled during the hand-over cycle.
- R5: While `loop_closed` is high, `pwm_period` equals the `comp_period` of the previous cycle. `on_time` equals `pwm_period`/2 − 200, or 0 when `pwm_period`/2 ≤ 200.
- R6: In the closed-loop ramp, each `tick` raises `vref` by `REF_STEP` (8), clamped to `vref_target`. `done` rises the cycle after `vref` equals the target.
- R7: `sr_en` is 0 while idle, during the open-loop stage and during the hand-over cycle. It is 1 during the closed-loop ramp and after `done`.
- R8: `abort` sampled high forces, on the next cycle, `on_time` = 0, `vref` = 0, `pwm_period` = 4000 and `sr_en` = `loop_closed` = `done` = 0. This applies in every state, and the block is idle afterwards.
- R9: `start_req` has no effect outside the idle state.
- R10: When the pre-bias `vout_meas` is at or above `vref_target`, `vref` is loaded with the target and `done` rises on the following cycle.
- R11: After `done`, `vref` follows `vref_target` with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle pulse marking each slow control step |
| start_req | input | 1 | Request to begin the start-up sequence |
| abort | input | 1 | Return to idle immediately |
| vout_meas | input | 12 | Measured output voltage, reference units |
| vref_target | input | 12 | Target reference set-point |
| comp_period | input | 16 | Period requested by the compensator, 250 ps counts |
| pwm_period | output | 16 | Switching period for the PWM generator |
| on_time | output | 16 | Primary on-time for the PWM generator |
| vref | output | 12 | Voltage reference for the compensator |
| sr_en | output | 1 | Synchronous rectifier drive enable |
| loop_closed | output | 1 | Compensator owns the period |
| done | output | 1 | Reference ramp complete |

## Verification
The hardest situations to reach are the stage boundaries: the exact tick on which the open-loop on-time reaches 1800, and the hand-over cycle in which `vout_meas` is captured. The stimulus reaches them by running full ramps with sparse and dense tick patterns. It also changes `comp_period` to a value small enough to force the on-time clamp. The pre-bias-above-target case is reached by aborting a finished run and restarting with `vout_meas` raised over the set-point. A second abort lands in the middle of the open-loop ramp.

// File: rtl/softstart_pkg.sv
// Shared types for the soft-start sequencer.
package softstart_pkg;
    // Sequencer stages: idle, open-loop duty ramp, one-cycle hand-over,
    // closed-loop reference ramp, and ramp finished.
    typedef enum logic [2:0] {
        SS_IDLE     = 3'd0,
        SS_OPEN     = 3'd1,
        SS_HANDOVER = 3'd2,
        SS_CLOSED   = 3'd3,
        SS_HOLD     = 3'd4
    } ss_state_e;
endpackage

// File: rtl/ss_fsm.sv
// Stage controller for the soft-start sequencer.
// Assumes the ramp units report their end conditions combinationally
// from their own registered values. Abort has priority over everything.
module ss_fsm
    import softstart_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_req,
    input  logic      abort,
    input  logic      ol_at_end,
    input  logic      ref_at_target,
    output ss_state_e state_o
);
    ss_state_e state_q;
    ss_state_e state_d;

    // Next-stage selection.
    always_comb begin
        state_d = state_q;
        if (abort) begin
            state_d = SS_IDLE;
        end else begin
            case (state_q)
                SS_IDLE:     if (start_req) state_d = SS_OPEN;
                SS_OPEN:     if (ol_at_end) state_d = SS_HANDOVER;
                SS_HANDOVER: state_d = SS_CLOSED;
                SS_CLOSED:   if (ref_at_target) state_d = SS_HOLD;
                SS_HOLD:     state_d = SS_HOLD;
                default:     state_d = SS_IDLE;
            endcase
        end
    end

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SS_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // R8
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> state_q == SS_IDLE);
    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SS_HOLD && !abort) |=> state_q == SS_HOLD);
endmodule

// File: rtl/ss_ontime_ramp.sv
// Open-loop on-time ramp. Loads the minimum on-time, then adds a fixed
// step per advance and saturates at the end value.
// Assumes ON_MIN <= ON_END and that both fit in W bits.
module ss_ontime_ramp #(
    parameter int W      = 16,
    parameter int ON_MIN = 200,
    parameter int STEP   = 10,
    parameter int ON_END = 1800
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    output logic [W-1:0] on_o,
    output logic         at_end_o
);
    localparam logic [W:0] END_EXT = (W+1)'(ON_END);

    logic [W-1:0] on_q;
    logic [W:0]   sum;

    // Saturating increment.
    always_comb begin
        sum = {1'b0, on_q} + (W+1)'(STEP);
        if (sum > END_EXT) sum = END_EXT;
    end

    // On-time register.
    always_ff @(posedge clk) begin
        if (!rst_n)    on_q <= '0;
        else if (load) on_q <= W'(ON_MIN);
        else if (adv)  on_q <= sum[W-1:0];
    end

    assign on_o     = on_q;
    assign at_end_o = (on_q == W'(ON_END));

    // R4
    ol_no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> on_q <= W'(ON_END));
endmodule

// File: rtl/ss_ref_ramp.sv
// Voltage reference ramp. Clears, loads a pre-bias value, steps toward
// the target without overshoot, or tracks the target once finished.
// Assumes load_val has already been limited to the target by the caller.
module ss_ref_ramp #(
    parameter int RW   = 12,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [RW-1:0] load_val,
    input  logic          adv,
    input  logic          track,
    input  logic [RW-1:0] target,
    output logic [RW-1:0] ref_o,
    output logic          at_target_o
);
    logic [RW-1:0] ref_q;
    logic [RW:0]   sum;

    // Clamped step toward the target.
    always_comb begin
        sum = {1'b0, ref_q} + (RW+1)'(STEP);
        if (sum > {1'b0, target}) sum = {1'b0, target};
    end

    // Reference register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ref_q <= '0;
        else if (clr)    ref_q <= '0;
        else if (load)   ref_q <= load_val;
        else if (adv)    ref_q <= sum[RW-1:0];
        else if (track)  ref_q <= target;
    end

    assign ref_o       = ref_q;
    assign at_target_o = (ref_q == target);

    // R6
    ref_no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !load) |=> ref_q <= $past(target));
endmodule

// File: rtl/softstart_seq.sv
// Soft-start sequencer top. Drives period, on-time and reference for a
// resonant half-bridge through an open-loop duty ramp and a closed-loop
// reference ramp. Times are 250 ps counts. Assumes tick is a one-cycle
// pulse and that comp_period is already limited by the compensator.
module softstart_seq
    import softstart_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int REF_W    = 12,
    parameter int PER_MAX  = 4000,
    parameter int ON_MIN   = 200,
    parameter int OL_STEP  = 10,
    parameter int DEAD     = 200,
    parameter int REF_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_req,
    input  logic             abort,
    input  logic [REF_W-1:0] vout_meas,
    input  logic [REF_W-1:0] vref_target,
    input  logic [CNT_W-1:0] comp_period,
    output logic [CNT_W-1:0] pwm_period,
    output logic [CNT_W-1:0] on_time,
    output logic [REF_W-1:0] vref,
    output logic             sr_en,
    output logic             loop_closed,
    output logic             done
);
    localparam int ON_OL_END = PER_MAX / 2 - DEAD;
    localparam logic [CNT_W-1:0] PER_FIX = CNT_W'(PER_MAX);
    localparam logic [CNT_W-1:0] DEAD_C  = CNT_W'(DEAD);

    ss_state_e        state;
    logic             ol_at_end;
    logic             ref_at_target;
    logic [CNT_W-1:0] on_ol;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] half_per;
    logic [CNT_W-1:0] on_cl;
    logic [REF_W-1:0] prebias;
    logic             closed_st;

    ss_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_req     (start_req),
        .abort         (abort),
        .ol_at_end     (ol_at_end),
        .ref_at_target (ref_at_target),
        .state_o       (state)
    );

    ss_ontime_ramp #(
        .W      (CNT_W),
        .ON_MIN (ON_MIN),
        .STEP   (OL_STEP),
        .ON_END (ON_OL_END)
    ) u_ol (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == SS_IDLE && start_req && !abort),
        .adv      (state == SS_OPEN && tick && !abort),
        .on_o     (on_ol),
        .at_end_o (ol_at_end)
    );

    // Pre-bias capture value, limited to the target.
    always_comb begin
        prebias = (vout_meas >= vref_target) ? vref_target : vout_meas;
    end

    ss_ref_ramp #(
        .RW   (REF_W),
        .STEP (REF_STEP)
    ) u_ref (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (abort),
        .load        (state == SS_HANDOVER),
        .load_val    (prebias),
        .adv         (state == SS_CLOSED && tick),
        .track       (state == SS_HOLD),
        .target      (vref_target),
        .ref_o       (vref),
        .at_target_o (ref_at_target)
    );

    assign closed_st = (state == SS_HANDOVER) || (state == SS_CLOSED) || (state == SS_HOLD);

    // Period register: fixed while open, compensator-owned once closed.
    always_ff @(posedge clk) begin
        if (!rst_n)                  per_q <= PER_FIX;
        else if (abort || !closed_st) per_q <= PER_FIX;
        else                         per_q <= comp_period;
    end

    // Closed-loop on-time: half period less dead time, floored at zero.
    always_comb begin
        half_per = per_q >> 1;
        on_cl    = (half_per > DEAD_C) ? (half_per - DEAD_C) : '0;
    end

    // Output selection by stage.
    always_comb begin
        pwm_period  = per_q;
        loop_closed = closed_st;
        sr_en       = (state == SS_CLOSED) || (state == SS_HOLD);
        done        = (state == SS_HOLD);
        case (state)
            SS_OPEN:                             on_time = on_ol;
            SS_HANDOVER, SS_CLOSED, SS_HOLD:     on_time = on_cl;
            default:                             on_time = '0;
        endcase
    end

    // R8
    abort_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (on_time == '0 && vref == '0 && !sr_en && !done));
    // R3
    ol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_OPEN && !tick && !abort) |=> on_time == $past(on_time));
    // R4
    handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SS_OPEN && ol_at_end && !abort) |=> (loop_closed && !sr_en));
    // R5
    period_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_closed && $past(loop_closed)) |-> pwm_period == $past(comp_period));
    // R7
    sr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_closed |-> !sr_en);
    // R11
    track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> vref == $past(vref_target));
endmodule

// File: tb/tb_softstart_seq.sv
// Self-checking bench with a behavioural reference model compared on every cycle.
module tb_softstart_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        start_req = 1'b0;
    logic        abort = 1'b0;
    logic [11:0] vout_meas = 12'd0;
    logic [11:0] vref_target = 12'd0;
    logic [15:0] comp_period = 16'd4000;
    logic [15:0] pwm_period;
    logic [15:0] on_time;
    logic [11:0] vref;
    logic        sr_en;
    logic        loop_closed;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;

    // 250 MHz clock
    always #2 clk = ~clk;

    softstart_seq dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req), .abort(abort),
        .vout_meas(vout_meas), .vref_target(vref_target), .comp_period(comp_period),
        .pwm_period(pwm_period), .on_time(on_time), .vref(vref), .sr_en(sr_en),
        .loop_closed(loop_closed), .done(done)
    );

    // Reference model: stage 0 idle, 1 open ramp, 2 hand-over, 3 closed ramp, 4 finished
    int m_stage = 0;
    int m_on = 0;
    int m_ref = 0;
    int m_per = 4000;

    always @(posedge clk) begin
        int old;
        old = m_stage;
        if (!rst_n) begin
            m_stage = 0; m_on = 0; m_ref = 0; m_per = 4000;
        end else begin
            if (abort) begin
                m_stage = 0; m_ref = 0;
            end else begin
                case (old)
                    0: if (start_req) begin m_stage = 1; m_on = 200; end
                    1: if (m_on == 1800) m_stage = 2;
                       else if (tick) m_on = (m_on + 10 > 1800) ? 1800 : m_on + 10;
                    2: begin
                        m_ref = (int'(vout_meas) < int'(vref_target)) ? int'(vout_meas) : int'(vref_target);
                        m_stage = 3;
                    end
                    3: if (m_ref == int'(vref_target)) m_stage = 4;
                       else if (tick) m_ref = (m_ref + 8 > int'(vref_target)) ? int'(vref_target) : m_ref + 8;
                    default: m_ref = int'(vref_target);
                endcase
            end
            m_per = (!abort && old >= 2) ? int'(comp_period) : 4000;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            int e_on;
            if (m_stage == 1) e_on = m_on;
            else if (m_stage >= 2) e_on = (m_per / 2 > 200) ? m_per / 2 - 200 : 0;
            else e_on = 0;
            chk(int'(pwm_period) == m_per, "R5", "pwm_period", int'(pwm_period), m_per);
            chk(int'(on_time) == e_on, "R3", "on_time", int'(on_time), e_on);
            chk(int'(vref) == m_ref, "R6", "vref", int'(vref), m_ref);
            chk(sr_en == (m_stage == 3 || m_stage == 4), "R7", "sr_en", int'(sr_en), int'(m_stage == 3 || m_stage == 4));
            chk(loop_closed == (m_stage >= 2), "R4", "loop_closed", int'(loop_closed), int'(m_stage >= 2));
            chk(done == (m_stage == 4), "R6", "done", int'(done), int'(m_stage == 4));
        end
    end

    task automatic run(input int n, input int tick_div);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = (tick_div > 0) && (i % tick_div == 0);
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
    endtask

    task automatic wait_closed(input int tick_div);
        for (int i = 0; i < 2000 && !loop_closed; i++) begin
            @(negedge clk);
            tick = (tick_div > 0) && (i % tick_div == 0);
        end
        tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        vout_meas = 12'd300; vref_target = 12'd1000; comp_period = 16'd4200;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pwm_period == 16'd4000 && on_time == 16'd0 && vref == 12'd0 &&
            !sr_en && !loop_closed && !done, "R1", "reset outputs", int'(on_time), 0);

        // R2 start loads minimum on-time
        pulse_start();
        chk(on_time == 16'd200, "R2", "on_time after start", int'(on_time), 200);
        chk(pwm_period == 16'd4000, "R2", "period after start", int'(pwm_period), 4000);

        // R3 five sparse ticks
        run(15, 3);
        chk(on_time == 16'd250, "R3", "on_time after 5 ticks", int'(on_time), 250);

        // R9 start during ramp ignored
        pulse_start();
        chk(on_time == 16'd250, "R9", "on_time after busy start", int'(on_time), 250);

        // R4 ramp to end, hand-over
        wait_closed(2);
        chk(on_time == 16'd1800, "R4", "on_time at hand-over", int'(on_time), 1800);
        chk(!sr_en, "R7", "sr_en at hand-over", int'(sr_en), 0);
        @(negedge clk);
        chk(vref == 12'd300, "R4", "pre-bias vref", int'(vref), 300);
        chk(sr_en, "R7", "sr_en closed ramp", int'(sr_en), 1);

        // R5 period follows compensator, on-time follows
        comp_period = 16'd5000;
        @(negedge clk);
        chk(pwm_period == 16'd5000 && on_time == 16'd2300, "R5", "on_time at 5000", int'(on_time), 2300);
        comp_period = 16'd300;
        @(negedge clk);
        chk(on_time == 16'd0, "R5", "on_time clamp", int'(on_time), 0);
        comp_period = 16'd4200;

        // R6 reference ramp to target
        for (int i = 0; i < 500 && !done; i++) begin
            @(negedge clk);
            tick = (i % 2 == 0);
        end
        tick = 1'b0;
        chk(done && vref == 12'd1000, "R6", "vref at done", int'(vref), 1000);

        // R11 tracking after done
        vref_target = 12'd1100;
        run(1, 0);
        chk(vref == 12'd1100, "R11", "vref tracks target", int'(vref), 1100);

        // R8 abort from finished state
        pulse_abort();
        chk(on_time == 16'd0 && vref == 12'd0 && !sr_en && !loop_closed && !done &&
            pwm_period == 16'd4000, "R8", "abort outputs", int'(vref), 0);

        // R10 pre-bias above target
        vout_meas = 12'd2000;
        pulse_start();
        wait_closed(1);
        @(negedge clk);
        chk(vref == 12'd1100, "R10", "vref clamped to target", int'(vref), 1100);
        @(negedge clk);
        chk(done, "R10", "done after clamp", int'(done), 1);

        // R8 abort during open-loop ramp
        pulse_abort();
        vout_meas = 12'd100;
        pulse_start();
        run(8, 1);
        pulse_abort();
        chk(on_time == 16'd0 && !loop_closed, "R8", "abort mid ramp", int'(on_time), 0);
        run(4, 1);
        chk(on_time == 16'd0, "R8", "idle after abort", int'(on_time), 0);

        finish_run();
    end
endmodule